// File: doc/BRIEF.md
# Quad UART Special Register Unit

This block sits next to four 16550-style UART register files that share one 32-byte I/O window. It splits the byte address into a port number (upper two bits) and a register offset (lower three bits), raises one chip-select per UART for ordinary accesses, and returns the addressed UART's read data in the same cycle. It also watches every write to a UART Line Control Register (offset 3) and records bit 7, the divisor-latch access bit, from the most recent such write to any port.

At offset 7 of any port, unless the scratchpad strap is active, the block answers in place of the UART scratchpad. The recorded DLAB bit picks one of two registers: a read-only interrupt status register that shows which UARTs are asking for service, or an options register. The options register holds two identification bits, which read back transformed so that software can detect the feature, and a 2-bit clock-rate multiplier field. The block drives the effective multiplier select, with jumper inputs taking priority over the software field, and merges the four UART interrupt lines into one level interrupt.

The selection is kept by a two-state machine. State `SEL_STATUS` (the reset state) routes offset 7 to the interrupt status register; state `SEL_OPTIONS` routes it to the options register. Transition `to_options` is taken on an LCR write with bit 7 = 1, transition `to_status` on an LCR write with bit 7 = 0; with no LCR write the state holds.

Top module: `quad_uart_spreg`

## Requirements
- R1: Address bits [4:3] select the port (0..3) and bits [2:0] the register offset. A read or write at any offset other than 7 raises exactly the chip-select bit of that port in the same cycle, and a read returns that UART's data byte (`uart_rdata[8*port +: 8]`) in the same cycle.
- R2: With `scratch_en` low, an access at offset 7 of any port raises no chip-select and is served by the special registers; with `scratch_en` high, offset 7 is treated like any other offset (chip-select raised, UART data returned, special registers untouched).
- R3: A write at offset 3 of any port records bit 7 of the written byte; from the next cycle, 0 selects the interrupt status register and 1 the options register at offset 7. After reset the interrupt status register is selected.
- R4: The interrupt status register reads `uart_irq` in bits 3..0 (bit n = port n) and 0 in bits 7..4; writes to it are ignored and leave the options register unchanged.
- R5: `irq_out` is high in any cycle where at least one `uart_irq` bit is high and low when none is.
- R6: The options register resets to all zeros; bits 5..2 always read 0, bits 1..0 read the multiplier field as last written.
- R7: Options bit 7 reads the AND and bit 6 the XOR of the values last written to bits 7 and 6.
- R8: `clk_mul_sel` encodes 00=x1, 01=x2, 10=x4, 11=x8. When a force input is high it overrides the software field, with priority `force_x8` over `force_x4` over `force_x2`; with none high it equals the software field (00 after reset). A field write shows on `clk_mul_sel` from the cycle after the write.
- R9: With neither `bus_rd` nor `bus_wr` high no chip-select is raised, and `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Byte address within the 32-byte window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| uart_cs | output | 4 | One chip-select per UART |
| uart_rdata | input | 32 | Read data of the four UARTs, port n in bits 8n+7..8n |
| uart_irq | input | 4 | Interrupt request of each UART |
| scratch_en | input | 1 | Strap: offset 7 goes to the UART scratchpads |
| force_x2 | input | 1 | Jumper forcing the x2 multiplier |
| force_x4 | input | 1 | Jumper forcing the x4 multiplier |
| force_x8 | input | 1 | Jumper forcing the x8 multiplier |
| irq_out | output | 1 | Combined level interrupt |
| clk_mul_sel | output | 2 | Effective clock multiplier select |

## Verification
Chip-selects, read data, the status register contents and `irq_out` are combinational, so they are due in the cycle the stimulus is applied; the recorded DLAB bit and the options register are latched by the edge that ends a write and become visible in the following cycle. The bench drives each access at a falling edge, compares combinational results two nanoseconds later, before the next rising edge, and reads back register effects only in a later access. Multiplier overrides are combinational on the force inputs and are sampled in the cycle they are applied.

// File: rtl/quad_spreg_pkg.sv
package quad_spreg_pkg;

    typedef enum logic {
        SEL_STATUS  = 1'b0,
        SEL_OPTIONS = 1'b1
    } spsel_e;

    typedef enum logic [1:0] {
        MUL_X1 = 2'b00,
        MUL_X2 = 2'b01,
        MUL_X4 = 2'b10,
        MUL_X8 = 2'b11
    } mul_e;

    localparam int OFF_W       = 3;
    localparam int SPECIAL_OFF = 7;
    localparam int LCR_OFF     = 3;
    localparam int DLAB_BIT    = 7;

endpackage

// File: rtl/spreg_addr_dec.sv
module spreg_addr_dec
    import quad_spreg_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int PORT_W = $clog2(NPORTS),
    localparam int ADDR_W = PORT_W + OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              scratch_en,
    output logic [PORT_W-1:0] port,
    output logic              special_hit,
    output logic              lcr_wr,
    output logic [NPORTS-1:0] cs
);

    logic [OFF_W-1:0] offset;
    logic             pass_through;

    always_comb begin
        port         = addr[ADDR_W-1:OFF_W];
        offset       = addr[OFF_W-1:0];
        special_hit  = (offset == OFF_W'(SPECIAL_OFF)) && !scratch_en;
        pass_through = (rd || wr) && !special_hit;
        lcr_wr       = wr && (offset == OFF_W'(LCR_OFF));
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_cs
        assign cs[g] = pass_through && (port == PORT_W'(g));
    end

endmodule

// File: rtl/spreg_dlab_fsm.sv
module spreg_dlab_fsm
    import quad_spreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lcr_wr,
    input  logic dlab_in,
    output logic sel_opt
);

    spsel_e state_q;
    spsel_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_STATUS:  if (lcr_wr && dlab_in)  state_d = SEL_OPTIONS;
            SEL_OPTIONS: if (lcr_wr && !dlab_in) state_d = SEL_STATUS;
            default:     state_d = SEL_STATUS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_STATUS;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SEL_STATUS:  sel_opt = 1'b0;
            SEL_OPTIONS: sel_opt = 1'b1;
            default:     sel_opt = 1'b0;
        endcase
    end

endmodule

// File: rtl/spreg_opt_reg.sv
module spreg_opt_reg
    import quad_spreg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          force_x2,
    input  logic          force_x4,
    input  logic          force_x8,
    output logic [DW-1:0] rdata,
    output logic [1:0]    mul_sel
);

    logic id_hi_q;
    logic id_lo_q;
    mul_e mul_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_hi_q <= 1'b0;
            id_lo_q <= 1'b0;
            mul_q   <= MUL_X1;
        end else if (wr_en) begin
            id_hi_q <= wdata[DW-1];
            id_lo_q <= wdata[DW-2];
            mul_q   <= mul_e'(wdata[1:0]);
        end
    end

    always_comb begin
        rdata       = '0;
        rdata[DW-1] = id_hi_q & id_lo_q;
        rdata[DW-2] = id_hi_q ^ id_lo_q;
        rdata[1:0]  = mul_q;
    end

    always_comb begin
        if (force_x8)      mul_sel = MUL_X8;
        else if (force_x4) mul_sel = MUL_X4;
        else if (force_x2) mul_sel = MUL_X2;
        else               mul_sel = mul_q;
    end

endmodule

// File: rtl/quad_uart_spreg.sv
module quad_uart_spreg
    import quad_spreg_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DW     = 8,
    localparam int PORT_W = $clog2(NPORTS),
    localparam int ADDR_W = PORT_W + OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic [NPORTS-1:0]    uart_cs,
    input  logic [NPORTS*DW-1:0] uart_rdata,
    input  logic [NPORTS-1:0]    uart_irq,
    input  logic                 scratch_en,
    input  logic                 force_x2,
    input  logic                 force_x4,
    input  logic                 force_x8,
    output logic                 irq_out,
    output logic [1:0]           clk_mul_sel
);

    logic [PORT_W-1:0] port;
    logic              special_hit;
    logic              lcr_wr;
    logic              sel_opt;
    logic [DW-1:0]     opt_rdata;
    logic [DW-1:0]     status_rdata;

    spreg_addr_dec #(.NPORTS(NPORTS)) u_dec (
        .addr        (bus_addr),
        .rd          (bus_rd),
        .wr          (bus_wr),
        .scratch_en  (scratch_en),
        .port        (port),
        .special_hit (special_hit),
        .lcr_wr      (lcr_wr),
        .cs          (uart_cs)
    );

    spreg_dlab_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .lcr_wr  (lcr_wr),
        .dlab_in (bus_wdata[DLAB_BIT]),
        .sel_opt (sel_opt)
    );

    spreg_opt_reg #(.DW(DW)) u_opt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && special_hit && sel_opt),
        .wdata    (bus_wdata),
        .force_x2 (force_x2),
        .force_x4 (force_x4),
        .force_x8 (force_x8),
        .rdata    (opt_rdata),
        .mul_sel  (clk_mul_sel)
    );

    always_comb begin
        status_rdata               = '0;
        status_rdata[NPORTS-1:0]   = uart_irq;
        irq_out                    = |uart_irq;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (special_hit) bus_rdata = sel_opt ? opt_rdata : status_rdata;
            else             bus_rdata = uart_rdata[port*DW +: DW];
        end
    end

endmodule

// File: rtl/spreg_checker.sv
module spreg_checker #(
    parameter int NPORTS = 4,
    parameter int DW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [NPORTS-1:0] uart_cs,
    input logic [NPORTS-1:0] uart_irq,
    input logic              scratch_en,
    input logic              force_x8,
    input logic              irq_out,
    input logic [1:0]        clk_mul_sel,
    input logic              sel_opt
);

    p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(uart_cs));

    p_no_cs_special_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scratch_en && bus_addr[2:0] == 3'd7) |-> (uart_cs == '0));

    p_dlab_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[2:0] == 3'd3) |=> (sel_opt == $past(bus_wdata[7])));

    p_status_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !scratch_en && bus_addr[2:0] == 3'd7 && !sel_opt)
            |-> (bus_rdata[7:4] == 4'h0));

    p_irq_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|uart_irq) |-> irq_out);

    p_irq_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_irq == '0) |-> !irq_out);

    p_opt_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !scratch_en && bus_addr[2:0] == 3'd7 && sel_opt)
            |-> (bus_rdata[5:2] == 4'h0));

    p_force_x8_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_x8 |-> (clk_mul_sel == 2'b11));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |-> (uart_cs == '0 && bus_rdata == '0));

endmodule

bind quad_uart_spreg spreg_checker #(.NPORTS(NPORTS), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .uart_cs     (uart_cs),
    .uart_irq    (uart_irq),
    .scratch_en  (scratch_en),
    .force_x8    (force_x8),
    .irq_out     (irq_out),
    .clk_mul_sel (clk_mul_sel),
    .sel_opt     (sel_opt)
);

// File: tb/quad_uart_spreg_tb.sv
module quad_uart_spreg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  uart_cs;
    logic [31:0] uart_rdata = 32'hD3C2B1A0;
    logic [3:0]  uart_irq = '0;
    logic        scratch_en = 1'b0;
    logic        force_x2 = 1'b0;
    logic        force_x4 = 1'b0;
    logic        force_x8 = 1'b0;
    logic        irq_out;
    logic [1:0]  clk_mul_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    quad_uart_spreg dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .uart_cs     (uart_cs),
        .uart_rdata  (uart_rdata),
        .uart_irq    (uart_irq),
        .scratch_en  (scratch_en),
        .force_x2    (force_x2),
        .force_x4    (force_x4),
        .force_x8    (force_x8),
        .irq_out     (irq_out),
        .clk_mul_sel (clk_mul_sel)
    );

    // {rd, addr, wdata, irq, expected rdata, expected cs}
    localparam int NV = 19;
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 5'd1,  8'h00, 4'h0, 8'hA0, 4'b0001},
        {1'b1, 5'd9,  8'h00, 4'h0, 8'hB1, 4'b0010},
        {1'b1, 5'd18, 8'h00, 4'h0, 8'hC2, 4'b0100},
        {1'b1, 5'd29, 8'h00, 4'h0, 8'hD3, 4'b1000},
        {1'b1, 5'd7,  8'h00, 4'hA, 8'h0A, 4'b0000},
        {1'b0, 5'd15, 8'hFF, 4'h0, 8'h00, 4'b0000},
        {1'b1, 5'd23, 8'h00, 4'h5, 8'h05, 4'b0000},
        {1'b0, 5'd11, 8'h80, 4'h0, 8'h00, 4'b0010},
        {1'b1, 5'd31, 8'h00, 4'hF, 8'h00, 4'b0000},
        {1'b0, 5'd7,  8'hBD, 4'h0, 8'h00, 4'b0000},
        {1'b1, 5'd15, 8'h00, 4'h0, 8'h41, 4'b0000},
        {1'b0, 5'd23, 8'hC2, 4'h0, 8'h00, 4'b0000},
        {1'b1, 5'd7,  8'h00, 4'h0, 8'h82, 4'b0000},
        {1'b0, 5'd7,  8'h03, 4'h0, 8'h00, 4'b0000},
        {1'b1, 5'd7,  8'h00, 4'h0, 8'h03, 4'b0000},
        {1'b0, 5'd7,  8'h40, 4'h0, 8'h00, 4'b0000},
        {1'b1, 5'd7,  8'h00, 4'h0, 8'h40, 4'b0000},
        {1'b0, 5'd27, 8'h03, 4'h0, 8'h00, 4'b1000},
        {1'b1, 5'd7,  8'h00, 4'h3, 8'h03, 4'b0000}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Apply one access at a falling edge, sample 2 ns later, hold through the rising edge.
    task automatic access(input bit rd, input logic [4:0] a, input logic [7:0] wd);
        @(negedge clk);
        bus_rd = rd;
        bus_wr = !rd;
        bus_addr = a;
        bus_wdata = wd;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state: R3, R6, R8
        uart_irq = 4'b0001;
        access(1'b1, 5'd7, 8'h00);
        chk("R3 reset selects status", bus_rdata, 8'h01);
        chk("R8 reset multiplier x1", {6'd0, clk_mul_sel}, 8'h00);
        uart_irq = 4'b0000;
        idle();
        chk("R9 idle rdata", bus_rdata, 8'h00);
        chk("R9 idle cs", {4'd0, uart_cs}, 8'h00);
        chk("R5 irq low", {7'd0, irq_out}, 8'h00);

        // Vector table: R1 R2 R3 R4 R6 R7 R5
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_rd    = VEC[i][29];
            bus_wr    = !VEC[i][29];
            bus_addr  = VEC[i][28:24];
            bus_wdata = VEC[i][23:16];
            uart_irq  = VEC[i][15:12];
            #2;
            chk($sformatf("R1/R2/R3/R4/R6/R7 rdata vec %0d", i), bus_rdata, VEC[i][11:4]);
            chk($sformatf("R1/R2 cs vec %0d", i), {4'd0, uart_cs}, {4'd0, VEC[i][3:0]});
            chk($sformatf("R5 irq vec %0d", i), {7'd0, irq_out}, {7'd0, |VEC[i][15:12]});
        end
        uart_irq = 4'b0000;
        idle();

        // R8: software field then jumper override priority
        access(1'b0, 5'd3, 8'h80);
        access(1'b0, 5'd7, 8'h02);
        idle();
        chk("R8 software field x4", {6'd0, clk_mul_sel}, 8'h02);
        force_x2 = 1'b1; #1;
        chk("R8 force x2", {6'd0, clk_mul_sel}, 8'h01);
        force_x4 = 1'b1; #1;
        chk("R8 force x4 over x2", {6'd0, clk_mul_sel}, 8'h02);
        force_x8 = 1'b1; #1;
        chk("R8 force x8 over all", {6'd0, clk_mul_sel}, 8'h03);
        force_x2 = 1'b0; force_x4 = 1'b0; force_x8 = 1'b0; #1;
        chk("R8 release to software", {6'd0, clk_mul_sel}, 8'h02);

        // R2: scratchpad strap passes offset 7 to the UARTs
        scratch_en = 1'b1;
        access(1'b1, 5'd7, 8'h00);
        chk("R2 strap read data", bus_rdata, 8'hA0);
        chk("R2 strap read cs", {4'd0, uart_cs}, 8'h01);
        access(1'b0, 5'd15, 8'h05);
        chk("R2 strap write cs", {4'd0, uart_cs}, 8'h02);
        idle();
        scratch_en = 1'b0;
        access(1'b1, 5'd31, 8'h00);
        chk("R2 options untouched by strap write", bus_rdata, 8'h02);
        chk("R8 multiplier untouched by strap write", {6'd0, clk_mul_sel}, 8'h02);

        // R4: status write ignored while status selected
        access(1'b0, 5'd19, 8'h00);
        access(1'b0, 5'd7, 8'hC3);
        idle();
        chk("R4 status write ignored (multiplier)", {6'd0, clk_mul_sel}, 8'h02);
        access(1'b0, 5'd3, 8'h80);
        access(1'b1, 5'd7, 8'h00);
        chk("R4 status write ignored (options)", bus_rdata, 8'h02);
        idle();

        // R3/R6: reset during operation returns defaults
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk("R6 async reset clears multiplier", {6'd0, clk_mul_sel}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        uart_irq = 4'b1000;
        access(1'b1, 5'd7, 8'h00);
        chk("R3 status selected after reset", bus_rdata, 8'h08);
        chk("R5 irq high", {7'd0, irq_out}, 8'h01);
        access(1'b0, 5'd3, 8'h80);
        access(1'b1, 5'd7, 8'h00);
        chk("R6 options zero after reset", bus_rdata, 8'h00);
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule